// File: doc/BRIEF.md
# Timer with Serial Baud Tick

This block is a machine-cycle timer for a small controller core. It runs on the fast oscillator clock. A prescaler turns that clock into a machine-cycle enable that is high for one clock in every twelve. A pair of byte registers counts on that enable. In the wide mode the two bytes form one 16-bit up-counter, and its start value sets the interval before it wraps. In the reload mode only the low byte counts, and when it wraps it takes a fresh start value from the high byte. Every wrap sets a sticky overflow flag.

In the reload mode the wraps also drive a bit-rate divider, which emits a one-clock tick for a serial shifter. The divider divides the overflow stream by 32, or by 16 when the doubling bit is set. The tick rate is therefore f_osc · 2^dbl / (32 · 12 · (256 − reload)).

Software loads the registers through a single write port. The write port selects a target with a two-bit code:

| Code | Target |
|------|--------|
| 0 | low byte |
| 1 | high byte |
| 2 | clears the flag |
| 3 | doubling bit, taken from data bit 0 |

Top module: `timer_baud`

## Requirements
- R1: `mcyc_en` is high for exactly one clock in every 12 clocks.
- R2: While `run_en` is low, the count registers hold their value. While `run_en` is high, the count advances once per `mcyc_en` clock.
- R3: In wide mode (`mode_sel`=0), `{cnt_hi,cnt_lo}` is one 16-bit up-counter. When it is loaded with 65536−N, it wraps to 0 and sets `ovf_flag` at the edge of the Nth machine-cycle enable, and not before.
- R4: In reload mode (`mode_sel`=1), only `cnt_lo` counts. When it wraps from 0xFF, it is loaded with `cnt_hi`, `ovf_flag` is set, and `cnt_hi` does not change.
- R5: `ovf_flag` stays set until a write with select code 2 clears it. If a wrap and a clear happen in the same cycle, the wrap wins.
- R6: A write to the low byte (code 0) or to the high byte (code 1) blocks the count step in that cycle, and the written value is stored.
- R7: `baud_tick` pulses only in reload mode, once per 32 overflows (doubling bit 0) or once per 16 overflows (doubling bit 1). Its period is therefore 12·(256−reload)·32/2^dbl clocks.
- R8: The bit-rate divider restarts from zero when `mode_sel` changes or when the doubling bit is written (code 3). The next tick then comes after a full 32 (or 16) overflows.
- R9: After reset, both count bytes, `ovf_flag`, the doubling bit and `baud_tick` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Allows the counter to advance |
| mode_sel | input | 1 | 0 selects the wide 16-bit mode, 1 selects the 8-bit reload mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low byte, 1 high byte, 2 flag clear, 3 doubling bit |
| wr_data | input | 8 | Write data |
| mcyc_en | output | 1 | Machine-cycle enable |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| baud_tick | output | 1 | One-clock serial bit-rate tick |

## Verification
`mcyc_en` is decoded from prescaler state. The bench therefore reads it at a falling edge and treats the next rising edge as the edge where that enable takes effect. The count bytes, `ovf_flag` and `baud_tick` all change at that same rising edge, so each check samples them at the falling edge that follows. To find exactly when a result is due, the bench counts the enables seen at falling edges since the stimulus and compares that count with the expected number. This is how it checks the 16-bit interval, the reload and the restarted divider. Tick spacing is measured in clocks between two falling edges that show `baud_tick`, and each measurement is compared with the rate formula within one clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned OSC_DIV   = 12;
    localparam int unsigned BAUD_BASE = 32;

    typedef enum logic {
        MODE_W16 = 1'b0,
        MODE_R8  = 1'b1
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_DBL  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_pair_t;

    function automatic logic is_cnt_sel(input wr_sel_e s);
        return (s == SEL_LO) || (s == SEL_HI);
    endfunction

endpackage

// File: rtl/mcyc_prescaler.sv
module mcyc_prescaler #(
    parameter int unsigned DIV = tmr_pkg::OSC_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic mc_en
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                  phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign mc_en = (phase_q == LAST);

    AST_MC_SPACED: assert property (@(posedge clk) disable iff (rst)
        mc_en |=> !mc_en); // R1

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mc_en,
    input  logic                 run_en,
    input  tmr_mode_e            mode,
    input  logic                 wr_en,
    input  wr_sel_e              wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output cnt_pair_t            cnt,
    output logic                 ovf_flag,
    output logic                 ovf_pulse
);
    cnt_pair_t cnt_q, cnt_nxt;
    logic      cnt_wr, step, wrap, flag_q, flag_clr;

    assign cnt_wr   = wr_en && is_cnt_sel(wr_sel);
    assign flag_clr = wr_en && (wr_sel == SEL_FLAG);
    assign step     = mc_en && run_en && !cnt_wr;

    always_comb begin
        cnt_nxt = cnt_q;
        wrap    = 1'b0;
        if (mode == MODE_W16) begin
            cnt_nxt = cnt_pair_t'(cnt_q + 1'b1);
            wrap    = step && (cnt_q == '1);
        end else begin
            wrap       = step && (cnt_q.lo == '1);
            cnt_nxt.lo = (cnt_q.lo == '1) ? cnt_q.hi : cnt_q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            if (wr_sel == SEL_LO) cnt_q.lo <= wr_data;
            else                  cnt_q.hi <= wr_data;
        end else if (step) begin
            cnt_q <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign cnt       = cnt_q;
    assign ovf_flag  = flag_q;
    assign ovf_pulse = wrap;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr_en) |=> $stable(cnt_q)); // R2
    AST_WIDE_WRAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && mode == MODE_W16) |=> (cnt_q == '0)); // R3
    AST_RELOAD_FROM_HI: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && mode == MODE_R8) |=> (cnt_q.lo == $past(cnt_q.hi) && $stable(cnt_q.hi))); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_LO) |=> (cnt_q.lo == $past(wr_data))); // R6

endmodule

// File: rtl/baud_div.sv
module baud_div
    import tmr_pkg::*;
#(
    parameter int unsigned BASE = tmr_pkg::BAUD_BASE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      ovf_pulse,
    input  tmr_mode_e mode,
    input  logic      dbl,
    output logic      tick
);
    localparam int unsigned DW = $clog2(BASE);
    localparam logic [DW-1:0] LIM_SLOW = DW'(BASE - 1);
    localparam logic [DW-1:0] LIM_FAST = DW'(BASE / 2 - 1);

    logic [DW-1:0] div_q, limit;
    logic          tick_q, count_en;

    assign limit    = dbl ? LIM_FAST : LIM_SLOW;
    assign count_en = ovf_pulse && (mode == MODE_R8);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (count_en) begin
                if (div_q == limit) begin
                    div_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign tick = tick_q;

    AST_TICK_FROM_OVF: assert property (@(posedge clk) disable iff (rst)
        tick |-> ($past(ovf_pulse) && $past(mode) == MODE_R8)); // R7
    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!tick && div_q == '0)); // R8

endmodule

// File: rtl/timer_baud.sv
module timer_baud
    import tmr_pkg::*;
#(
    parameter int unsigned PRESCALE  = tmr_pkg::OSC_DIV,
    parameter int unsigned BAUD_DIVN = tmr_pkg::BAUD_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              mode_sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              mcyc_en,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_flag,
    output logic              baud_tick
);
    tmr_mode_e mode_e, mode_q;
    wr_sel_e   sel_e;
    cnt_pair_t cnt;
    logic      ovf_pulse, dbl_q, dbl_wr, div_clr;

    assign mode_e  = tmr_mode_e'(mode_sel);
    assign sel_e   = wr_sel_e'(wr_sel);
    assign dbl_wr  = wr_en && (sel_e == SEL_DBL);
    assign div_clr = dbl_wr || (mode_e != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dbl_q  <= 1'b0;
            mode_q <= MODE_W16;
        end else begin
            mode_q <= mode_e;
            if (dbl_wr) dbl_q <= wr_data[0];
        end
    end

    mcyc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .mc_en (mcyc_en)
    );

    tmr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .mc_en     (mcyc_en),
        .run_en    (run_en),
        .mode      (mode_e),
        .wr_en     (wr_en),
        .wr_sel    (sel_e),
        .wr_data   (wr_data),
        .cnt       (cnt),
        .ovf_flag  (ovf_flag),
        .ovf_pulse (ovf_pulse)
    );

    baud_div #(.BASE(BAUD_DIVN)) u_baud (
        .clk       (clk),
        .rst       (rst),
        .clr       (div_clr),
        .ovf_pulse (ovf_pulse),
        .mode      (mode_e),
        .dbl       (dbl_q),
        .tick      (baud_tick)
    );

    assign cnt_lo = cnt.lo;
    assign cnt_hi = cnt.hi;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!ovf_flag && !baud_tick && !dbl_q)); // R9

endmodule

// File: tb/timer_baud_tb.sv
module timer_baud_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic       mode_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       mcyc_en, ovf_flag, baud_tick;
    logic [7:0] cnt_lo, cnt_hi;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    localparam int NV = 6;
    localparam logic [7:0] VEC_RELOAD [NV] = '{8'd250, 8'd250, 8'd200, 8'd255, 8'd255, 8'd240};
    localparam bit         VEC_DBL    [NV] = '{1'b0,  1'b1,  1'b1,  1'b0,  1'b1,  1'b0};

    always #5 clk = ~clk;

    timer_baud u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mcyc_en(mcyc_en), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ovf_flag(ovf_flag), .baud_tick(baud_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // wait until a negedge where mcyc_en is high, then step to a quiet negedge
    task automatic quiet_after_enable();
        do @(negedge clk); while (!mcyc_en);
        @(negedge clk);
    endtask

    // count machine-cycle enables while run_en is high; returns after n of them
    task automatic run_enables(input int n);
        int seen = 0;
        run_en = 1'b1;
        while (seen < n) begin
            @(negedge clk);
            if (mcyc_en) seen++;
        end
        @(negedge clk);
        run_en = 1'b0;
    endtask

    initial begin
        int t0, t1, exp, passed, e, tick_at;
        bit found;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(cnt_lo == 0 && cnt_hi == 0, "R9 count", {cnt_hi, cnt_lo}, 0);
        check(!ovf_flag && !baud_tick, "R9 flag/tick", {ovf_flag, baud_tick}, 0);

        // R1 enable spacing
        do @(negedge clk); while (!mcyc_en);
        t0 = cyc;
        do @(negedge clk); while (!mcyc_en);
        t1 = cyc;
        check(t1 - t0 == 12, "R1 spacing", t1 - t0, 12);
        @(negedge clk);
        check(!mcyc_en, "R1 single", mcyc_en, 0);

        // R2 hold while stopped, then advance once per enable
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h00);
        repeat (30) @(negedge clk);
        check({cnt_hi, cnt_lo} == 16'h0010, "R2 hold", {cnt_hi, cnt_lo}, 16'h0010);
        run_enables(7);
        check({cnt_hi, cnt_lo} == 16'h0017, "R2 advance", {cnt_hi, cnt_lo}, 16'h0017);

        // R3 16-bit interval: load 65536-3000 = 0xF448
        wr(2'd0, 8'h48);
        wr(2'd1, 8'hF4);
        wr(2'd2, 8'h00);
        passed = 0;
        found = 0;
        run_en = 1'b1;
        while (!found && passed < 3100) begin
            @(negedge clk);
            if (ovf_flag) found = 1;
            else if (mcyc_en) passed++;
        end
        run_en = 1'b0;
        check(found && passed == 3000, "R3 interval", passed, 3000);
        check({cnt_hi, cnt_lo} == 0, "R3 wrap to zero", {cnt_hi, cnt_lo}, 0);

        // R5 sticky flag, cleared by write code 2
        repeat (40) @(negedge clk);
        check(ovf_flag == 1'b1, "R5 sticky", ovf_flag, 1);
        wr(2'd2, 8'h00);
        check(ovf_flag == 1'b0, "R5 clear", ovf_flag, 0);

        // R4 reload mode: hi=F0, lo=FE, two enables -> lo=F0
        mode_sel = 1'b1;
        wr(2'd1, 8'hF0);
        wr(2'd0, 8'hFE);
        run_enables(2);
        check(cnt_lo == 8'hF0, "R4 reload lo", cnt_lo, 8'hF0);
        check(cnt_hi == 8'hF0, "R4 hi kept", cnt_hi, 8'hF0);
        check(ovf_flag == 1'b1, "R4 flag", ovf_flag, 1);

        // R6 write beats increment in the same cycle
        run_en = 1'b1;
        do @(negedge clk); while (!mcyc_en);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        check(cnt_lo == 8'h55, "R6 write priority", cnt_lo, 8'h55);
        run_en = 1'b0;
        wr(2'd2, 8'h00);

        // R8 doubling-bit write restarts divider (reload 0xFF: one overflow per enable)
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFF);
        run_en = 1'b1;
        repeat (10) begin
            do @(negedge clk); while (!mcyc_en);
        end
        quiet_after_enable();
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h00;
        e = 0; tick_at = -1;
        @(negedge clk);
        wr_en = 1'b0;
        while (tick_at < 0 && e < 40) begin
            if (baud_tick) tick_at = e;
            if (mcyc_en) e++;
            @(negedge clk);
        end
        check(tick_at == 32, "R8 dbl write restart", tick_at, 32);

        // R8 mode change restarts divider
        repeat (10) begin
            do @(negedge clk); while (!mcyc_en);
        end
        quiet_after_enable();
        mode_sel = 1'b0;
        @(negedge clk);
        mode_sel = 1'b1;
        e = 0; tick_at = -1;
        @(negedge clk);
        while (tick_at < 0 && e < 40) begin
            if (baud_tick) tick_at = e;
            if (mcyc_en) e++;
            @(negedge clk);
        end
        check(tick_at == 32, "R8 mode change restart", tick_at, 32);

        // R7 no tick in wide mode
        run_en = 1'b0;
        mode_sel = 1'b0;
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hF0);
        run_en = 1'b1;
        found = 0;
        repeat (600) begin
            @(negedge clk);
            if (baud_tick) found = 1;
        end
        run_en = 1'b0;
        check(!found, "R7 silent in wide mode", found, 0);

        // R7 vector table: tick spacing against the rate formula
        for (int i = 0; i < NV; i++) begin
            run_en = 1'b0;
            mode_sel = 1'b1;
            wr(2'd1, VEC_RELOAD[i]);
            wr(2'd0, VEC_RELOAD[i]);
            wr(2'd3, {7'd0, VEC_DBL[i]});
            run_en = 1'b1;
            do @(negedge clk); while (!baud_tick);
            t0 = cyc;
            do @(negedge clk); while (!baud_tick);
            t1 = cyc;
            exp = 12 * (256 - int'(VEC_RELOAD[i])) * (VEC_DBL[i] ? 16 : 32);
            check((t1 - t0 <= exp + 1) && (t1 - t0 >= exp - 1), "R7 tick spacing", t1 - t0, exp);
        end
        run_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule